// File: doc/BRIEF.md
# Boundary test-operation control engine

This block holds a three-bit scannable control word and the small engine it steers. While the run-test instruction is loaded and the test access port sits in run-test/idle, the engine advances a parallel boundary word by one step on each rising test-clock edge. The control word picks what a step does: pattern generation with a linear-feedback shift register, signature compaction of the parallel inputs into that register, or a plain binary up-count.

Software or a tester shifts a new control code in through the serial path, commits it with an update strobe, and then parks the port in run-test/idle for the wanted number of cycles. On leaving run-test/idle the boundary word holds still, so the result can be read out afterwards. The port controller and the instruction register sit outside the block and reach it only as strobes.

Top module: `bctl_engine`

## Requirements
- R1: With `ctl_sel` and `shift_dr` high, each rising `tck` moves `tdi` into bit 2 of the shift stage and moves bits 2..1 down to bits 1..0; `tdo` always shows bit 0, so a code shifted in least-significant bit first lands as written.
- R2: An active-low `trst_n` (asynchronous) or a `tlr` pulse (synchronous) sets both the shift stage and the active code to 3'b010; only `trst_n` clears `bword` to zero, and `tlr` leaves it unchanged.
- R3: A capture-DR strobe with the control register selected leaves the shift stage contents unchanged.
- R4: The active code changes only on a rising `tck` with `ctl_sel` and `update_dr` high, when it copies the shift stage; shifting alone does not change the running operation.
- R5: Active code 3'b000 selects pattern generation, 3'b001 selects counting, and every other code selects signature compaction.
- R6: `bword` takes one step per rising `tck` only while `runt_active` and `rti` are both high and `tlr` is low; otherwise it holds its value whatever `pin_in` does.
- R7: A pattern-generation step on a nonzero word s yields (s >> 1) XOR (s[0] ? MASK : 0), with MASK = 16'hB400 at the default width of 16.
- R8: A pattern-generation step on an all-zero word yields the seed, 16'h0001 by default.
- R9: A compaction step yields the pattern-generation shift of R7 applied to s (including from zero), XORed with `pin_in`.
- R10: A counting step yields s + 1 modulo 2^W, so 16'hFFFF steps to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset of all state |
| tlr | input | 1 | Port is in test-logic-reset; synchronous reset of the control code |
| capture_dr | input | 1 | Port is in capture-DR |
| shift_dr | input | 1 | Port is in shift-DR |
| update_dr | input | 1 | Port is in update-DR |
| rti | input | 1 | Port is in run-test/idle |
| runt_active | input | 1 | The run-test instruction is loaded |
| ctl_sel | input | 1 | The control register is the selected data register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift stage |
| pin_in | input | W | Parallel inputs compacted by the signature operation |
| bword | output | W | The boundary word the engine drives |

## Verification
Every result here is one register away from its cause: a shift, an update or a run-test step is visible on `tdo` or `bword` right after the rising edge that performs it, and the code read back on `tdo` during a shift is the bit present before that edge. The bench sets inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so each comparison sees the state produced by that one edge. Multi-step runs are compared after the last step against a reference word advanced once per edge from the same `pin_in` values that were driven.

// File: rtl/bctl_pkg.sv
package bctl_pkg;

   localparam int unsigned CFG_W = 3;
   localparam logic [CFG_W-1:0] CFG_RST = 3'b010;

   typedef enum logic [1:0] {
      OP_SIG  = 2'd0,
      OP_PATT = 2'd1,
      OP_CNT  = 2'd2
   } op_e;

   function automatic op_e decode_op(input logic [CFG_W-1:0] code);
      case (code)
         3'b000:  return OP_PATT;
         3'b001:  return OP_CNT;
         default: return OP_SIG;
      endcase
   endfunction

endpackage

// File: rtl/bctl_cfg_reg.sv
module bctl_cfg_reg
   import bctl_pkg::*;
(
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tlr,
   input  logic             sel,
   input  logic             capture,
   input  logic             shift,
   input  logic             update,
   input  logic             tdi,
   output logic             tdo,
   output logic [CFG_W-1:0] sh_q,
   output logic [CFG_W-1:0] act_q
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh_q  <= CFG_RST;
         act_q <= CFG_RST;
      end else if (tlr) begin
         sh_q  <= CFG_RST;
         act_q <= CFG_RST;
      end else begin
         if (sel && shift)
            sh_q <= {tdi, sh_q[CFG_W-1:1]};
         else if (sel && capture)
            sh_q <= sh_q;   // capture loads nothing into this register
         if (sel && update)
            act_q <= sh_q;
      end
   end

   assign tdo = sh_q[0];

endmodule

// File: rtl/bctl_next.sv
module bctl_next
   import bctl_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] SEED = 1
)(
   input  op_e          op,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] pin,
   output logic [W-1:0] nxt
);

   logic [W-1:0] mask;
   logic [W-1:0] shifted;

   if (W == 8) begin : g_w8
      assign mask = 8'hB8;
   end else if (W == 16) begin : g_w16
      assign mask = 16'hB400;
   end else if (W == 18) begin : g_w18
      assign mask = 18'h20400;
   end else if (W == 32) begin : g_w32
      assign mask = 32'h8020_0003;
   end else begin : g_bad_w
      $error("bctl_next: no feedback polynomial for this width");
      assign mask = '0;
   end

   if (SEED == '0) begin : g_bad_seed
      $error("bctl_next: seed must be nonzero");
   end

   assign shifted = {1'b0, cur[W-1:1]} ^ (cur[0] ? mask : '0);

   always_comb begin
      case (op)
         OP_PATT: nxt = (cur == '0) ? SEED : shifted;
         OP_CNT:  nxt = cur + 1'b1;
         default: nxt = shifted ^ pin;
      endcase
   end

endmodule

// File: rtl/bctl_engine.sv
module bctl_engine
   import bctl_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] SEED = 1
)(
   input  logic         tck,
   input  logic         trst_n,
   input  logic         tlr,
   input  logic         capture_dr,
   input  logic         shift_dr,
   input  logic         update_dr,
   input  logic         rti,
   input  logic         runt_active,
   input  logic         ctl_sel,
   input  logic         tdi,
   output logic         tdo,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] bword
);

   logic [CFG_W-1:0] cfg_sh;
   logic [CFG_W-1:0] cfg_act;
   logic [W-1:0]     word_q;
   logic [W-1:0]     word_d;
   logic             step;
   op_e              op;

   bctl_cfg_reg u_cfg (
      .tck     (tck),
      .trst_n  (trst_n),
      .tlr     (tlr),
      .sel     (ctl_sel),
      .capture (capture_dr),
      .shift   (shift_dr),
      .update  (update_dr),
      .tdi     (tdi),
      .tdo     (tdo),
      .sh_q    (cfg_sh),
      .act_q   (cfg_act)
   );

   assign op = decode_op(cfg_act);

   bctl_next #(.W(W), .SEED(SEED)) u_next (
      .op  (op),
      .cur (word_q),
      .pin (pin_in),
      .nxt (word_d)
   );

   assign step = runt_active && rti && !tlr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         word_q <= '0;
      else if (step)
         word_q <= word_d;
   end

   assign bword = word_q;

endmodule

// File: rtl/bctl_engine_chk.sv
module bctl_engine_chk #(
   parameter int unsigned W = 16
)(
   input logic         tck,
   input logic         trst_n,
   input logic         tlr,
   input logic         capture_dr,
   input logic         shift_dr,
   input logic         update_dr,
   input logic         rti,
   input logic         runt_active,
   input logic         ctl_sel,
   input logic         tdi,
   input logic [2:0]   cfg_sh,
   input logic [2:0]   cfg_act,
   input logic [W-1:0] bword
);

   p_shift_in_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (!tlr && ctl_sel && shift_dr) |=> (cfg_sh == {$past(tdi), $past(cfg_sh[2:1])}));

   p_tlr_code_r2: assert property (@(posedge tck) disable iff (!trst_n)
      tlr |=> (cfg_sh == 3'b010 && cfg_act == 3'b010));

   p_capture_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
      (!tlr && capture_dr && !shift_dr) |=> $stable(cfg_sh));

   p_update_only_r4: assert property (@(posedge tck) disable iff (!trst_n)
      (!tlr && !(ctl_sel && update_dr)) |=> $stable(cfg_act));

   p_idle_hold_r6: assert property (@(posedge tck) disable iff (!trst_n)
      !(runt_active && rti) |=> $stable(bword));

   p_nonzero_patt_r8: assert property (@(posedge tck) disable iff (!trst_n)
      (!tlr && runt_active && rti && cfg_act == 3'b000) |=> (bword != '0));

   p_count_up_r10: assert property (@(posedge tck) disable iff (!trst_n)
      (!tlr && runt_active && rti && cfg_act == 3'b001)
         |=> (bword == W'($past(bword) + 1'b1)));

endmodule

bind bctl_engine bctl_engine_chk #(.W(W)) u_chk (
   .tck         (tck),
   .trst_n      (trst_n),
   .tlr         (tlr),
   .capture_dr  (capture_dr),
   .shift_dr    (shift_dr),
   .update_dr   (update_dr),
   .rti         (rti),
   .runt_active (runt_active),
   .ctl_sel     (ctl_sel),
   .tdi         (tdi),
   .cfg_sh      (cfg_sh),
   .cfg_act     (cfg_act),
   .bword       (bword)
);

// File: tb/sim_bctl_engine.sv
module sim_bctl_engine;

   localparam int W = 16;
   localparam logic [W-1:0] MASK = 16'hB400;
   localparam logic [W-1:0] SEED = 16'h0001;
   localparam int NVEC = 8;
   // {code, pin base, step count}
   localparam logic [34:0] VEC [NVEC] = '{
      {3'b001, 16'h0000, 16'd20},
      {3'b000, 16'h0000, 16'd25},
      {3'b010, 16'hA5A5, 16'd17},
      {3'b011, 16'h1234, 16'd9},
      {3'b111, 16'hFFFF, 16'd12},
      {3'b101, 16'h0F0F, 16'd6},
      {3'b100, 16'h8001, 16'd30},
      {3'b110, 16'h3C3C, 16'd11}
   };

   logic tck = 1'b0;
   logic trst_n, tlr, capture_dr, shift_dr, update_dr, rti, runt_active, ctl_sel, tdi, tdo;
   logic [W-1:0] pin_in, bword;

   always #2 tck = ~tck;

   bctl_engine #(.W(W), .SEED(SEED)) u0 (
      .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .update_dr(update_dr), .rti(rti),
      .runt_active(runt_active), .ctl_sel(ctl_sel), .tdi(tdi), .tdo(tdo),
      .pin_in(pin_in), .bword(bword)
   );

   int checks = 0;
   int errors = 0;
   logic [W-1:0] m_word;
   logic [2:0]   m_act;
   logic [2:0]   old;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] shl(input logic [W-1:0] s);
      return {1'b0, s[W-1:1]} ^ (s[0] ? MASK : '0);
   endfunction

   function automatic logic [W-1:0] mstep(input logic [2:0] c, input logic [W-1:0] s,
                                          input logic [W-1:0] p);
      case (c)
         3'b000:  return (s == '0) ? SEED : shl(s);
         3'b001:  return s + 1'b1;
         default: return shl(s) ^ p;
      endcase
   endfunction

   task automatic tick;
      @(posedge tck);
      @(negedge tck);
   endtask

   task automatic scan(input logic [2:0] code, input bit do_upd, output logic [2:0] prev);
      ctl_sel  = 1'b1;
      shift_dr = 1'b1;
      for (int i = 0; i < 3; i++) begin
         prev[i] = tdo;
         tdi = code[i];
         tick();
      end
      shift_dr = 1'b0;
      if (do_upd) begin
         update_dr = 1'b1;
         tick();
         update_dr = 1'b0;
         m_act = code;
      end
      ctl_sel = 1'b0;
   endtask

   task automatic run(input logic [W-1:0] base, input int n);
      runt_active = 1'b1;
      rti = 1'b1;
      for (int i = 0; i < n; i++) begin
         pin_in = base ^ W'(i * 32'h1357);
         m_word = mstep(m_act, m_word, pin_in);
         tick();
      end
      rti = 1'b0;
   endtask

   task automatic step_pin(input logic [W-1:0] p);
      runt_active = 1'b1;
      rti = 1'b1;
      pin_in = p;
      m_word = mstep(m_act, m_word, p);
      tick();
      rti = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      trst_n = 1'b0; tlr = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
      rti = 1'b0; runt_active = 1'b0; ctl_sel = 1'b0; tdi = 1'b0; pin_in = '0;
      m_word = '0;
      m_act = 3'b010;
      tick();
      tick();
      trst_n = 1'b1;
      tick();

      // R2: reset state
      chk("R2 reset word", 32'(bword), 32'h0);
      chk("R2 reset tdo", 32'(tdo), 32'h0);

      // Vector walk; R1 readback of the previous code, R5/R7/R9/R10 results
      begin
         logic [2:0] prev_code;
         prev_code = 3'b010;
         for (int v = 0; v < NVEC; v++) begin
            scan(VEC[v][34:32], 1'b1, old);
            chk("R1 R2 code readback", 32'(old), 32'(prev_code));
            prev_code = VEC[v][34:32];
            run(VEC[v][31:16], int'(VEC[v][15:0]));
            chk("R5 R7 R9 R10 run result", 32'(bword), 32'(m_word));
         end
      end

      // R6: no step without both run-test instruction and run-test/idle
      runt_active = 1'b1; rti = 1'b0;
      for (int i = 0; i < 5; i++) begin pin_in = W'(i * 32'h7777); tick(); end
      chk("R6 hold outside idle", 32'(bword), 32'(m_word));
      runt_active = 1'b0; rti = 1'b1;
      for (int i = 0; i < 5; i++) begin pin_in = W'(i * 32'h3131); tick(); end
      rti = 1'b0;
      chk("R6 hold without instruction", 32'(bword), 32'(m_word));

      // R4: shifting without update keeps the running operation
      scan(3'b010, 1'b1, old);
      scan(3'b001, 1'b0, old);
      run(16'h5A5A, 3);
      chk("R4 op kept until update", 32'(bword), 32'(m_word));
      ctl_sel = 1'b1; update_dr = 1'b1; tick(); update_dr = 1'b0; ctl_sel = 1'b0;
      m_act = 3'b001;
      run(16'h0000, 2);
      chk("R4 op after update", 32'(bword), 32'(m_word));

      // R10: count wraps from all ones
      scan(3'b010, 1'b1, old);
      chk("R4 shift stage held 001", 32'(old), 32'h1);
      step_pin(shl(m_word) ^ 16'hFFFF);
      chk("R9 loaded all ones", 32'(bword), 32'hFFFF);
      scan(3'b001, 1'b1, old);
      step_pin(16'h0000);
      chk("R10 wrap to zero", 32'(bword), 32'h0);

      // R8: zero word under pattern generation takes the seed
      scan(3'b000, 1'b1, old);
      step_pin(16'hFFFF);
      chk("R8 seed from zero", 32'(bword), 32'(SEED));
      run(16'h0000, 4);
      chk("R7 pattern steps", 32'(bword), 32'(m_word));

      // R3: capture leaves the code in place
      scan(3'b101, 1'b1, old);
      ctl_sel = 1'b1; capture_dr = 1'b1; tick(); capture_dr = 1'b0; ctl_sel = 1'b0;
      scan(3'b000, 1'b1, old);
      chk("R3 capture no change", 32'(old), 32'h5);

      // R2: synchronous reset returns the code to compaction, word kept
      tlr = 1'b1; tick(); tlr = 1'b0;
      m_act = 3'b010;
      chk("R2 tlr keeps word", 32'(bword), 32'(m_word));
      scan(3'b011, 1'b0, old);
      chk("R2 tlr shift stage", 32'(old), 32'h2);
      run(16'hC3C3, 3);
      chk("R2 R5 tlr active code compacts", 32'(bword), 32'(m_word));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule